// File: doc/BRIEF.md
# Amplifier Fault Protection Manager

This block sits between the amplifier's analog protection sensors, whose outputs arrive already synchronized to the system clock, and the amplifier's output stage and volume control. It turns nine fault indications into four responses. An active-low open-drain diagnostic output is pulled low for faults that need outside attention. A sticky per-fault status word can be read and cleared by software. An output-float control puts the power stage in high impedance. A volume-reduce level and a one-cycle volume-restore pulse drive the separate volume ramp.

Faults fall into three recovery classes. A thermal warning only folds the volume back. Over-temperature and over-current float the outputs and recover by themselves once their condition has stayed clear for a fixed number of clock cycles. The supply, over-dissipation, output-window and clock-generator faults hold the outputs floating until a condition that shows the hazard is gone has been seen.

Top module: `amp_fault_mgr`

## Requirements
- R1: After reset, diag_n_o is 1, out_float_o is 0, vol_reduce_o is 0, vol_restore_o is 0 and flags_o is all zero.
- R2: A thermal warning sampled at a clock edge raises vol_reduce_o after that edge. It does not drive diag_n_o low or raise out_float_o. On the first edge that samples the warning low after it was high, vol_reduce_o falls and vol_restore_o is 1 for exactly one cycle.
- R3: Over-temperature or over-current sampled high drives diag_n_o low and out_float_o high after that edge. Both stay so until RECOVER_CYC consecutive edges have sampled the input low, and they are released after the last of those edges.
- R4: If an auto-recovering fault reasserts during its recovery wait, the wait starts over from zero.
- R5: Over-voltage (vmain_high_i) and under-voltage (vmain_low_i or vaux_low_i) drive diag_n_o low and float the outputs. Either is released only after an edge samples vmain_high_i, vmain_low_i and vaux_low_i all low.
- R6: Over-dissipation is active only while hot_dissip_i and over_curr_i are both high. It is released on the first edge at which either is low. It drives diag_n_o low and floats the outputs.
- R7: A window fault drives diag_n_o low and floats the outputs for as long as win_fault_i is sampled high. It is released on the first edge that samples it low.
- R8: PLL lock loss and PLL under-frequency float the outputs and set their flags, but leave diag_n_o at 1.
- R9: Flag bits are bit 0 thermal warning, 1 over-temperature, 2 over-current, 3 over-voltage, 4 under-voltage, 5 over-dissipation, 6 window fault, 7 PLL lock loss, 8 PLL under-frequency. A flag goes to 1 one cycle after its fault becomes active and stays 1 after the fault clears.
- R10: An edge with clr_we_i high clears every flag whose clr_mask_i bit is 1. Bits that are 0 in the mask are left as they are. A fault that is still active sets its flag again, so the clear has no effect on it.
- R11: out_float_o is the OR of all active fault states except the thermal warning. diag_n_o is low exactly while an over-temperature, over-current, over-voltage, under-voltage, over-dissipation or window fault is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| therm_warn_i | input | 1 | Junction above programmed warning threshold |
| over_temp_i | input | 1 | Junction above shutdown temperature |
| over_curr_i | input | 1 | Output current above limit |
| hot_dissip_i | input | 1 | Junction above dissipation threshold |
| vmain_high_i | input | 1 | Main supply above upper limit |
| vmain_low_i | input | 1 | Main supply below lower limit |
| vaux_low_i | input | 1 | Low-voltage supply below its limit |
| win_fault_i | input | 1 | Output too close to a supply rail or the reference |
| pll_unlock_i | input | 1 | PLL out of lock |
| pll_slow_i | input | 1 | PLL frequency below minimum |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 9 | Write-one-to-clear mask for flags |
| diag_n_o | output | 1 | Diagnostic, active-low open-drain style |
| flags_o | output | 9 | Sticky fault flags |
| out_float_o | output | 1 | Put output stage in high impedance |
| vol_reduce_o | output | 1 | Volume foldback request |
| vol_restore_o | output | 1 | One-cycle request to ramp back to user volume |

## Verification
The assertions check on every cycle that an over-temperature or under-voltage sample is followed by a low diagnostic and floating outputs, that PLL faults float the outputs, and that a restore pulse only follows the end of a foldback. They also check that a flag never falls without a matching clear write and that an over-current appears in its flag two cycles later. Only the bench's scenarios can show the exact length of the recovery wait and its restart on reassertion, the supply-release condition that needs all three supply inputs clear, the thermal warning leaving the pins alone, and the clear write leaving active and unmasked flags intact.

// File: rtl/afm_pkg.sv
package afm_pkg;
  localparam int unsigned NUM_FAULTS = 9;

  localparam int unsigned IDX_TW = 0;
  localparam int unsigned IDX_OT = 1;
  localparam int unsigned IDX_OC = 2;
  localparam int unsigned IDX_OV = 3;
  localparam int unsigned IDX_UV = 4;
  localparam int unsigned IDX_OD = 5;
  localparam int unsigned IDX_WP = 6;
  localparam int unsigned IDX_LK = 7;
  localparam int unsigned IDX_UF = 8;

  localparam int unsigned NUM_AUTO    = 2;
  localparam int unsigned NUM_RESTART = 6;

  typedef logic [NUM_FAULTS-1:0] fault_vec_t;

  localparam fault_vec_t DIAG_MASK  = fault_vec_t'(9'b0_0111_1110);
  localparam fault_vec_t FLOAT_MASK = fault_vec_t'(9'b1_1111_1110);
endpackage

// File: rtl/afm_autorec.sv
module afm_autorec #(
  parameter int unsigned RECOVER_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(RECOVER_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOVER_CYC - 1);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_en;

  assign upd_en = fault_i | act_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (fault_i) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/afm_restart.sv
module afm_restart (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic good_i,
  output logic active_o
);
  logic act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (set_i) begin
      act_d = 1'b1;
    end else if (good_i) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/afm_thermal.sv
module afm_thermal (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warn_i,
  output logic reduce_o,
  output logic restore_o
);
  logic warn_q, warn_d;
  logic rest_q, rest_d;

  always_comb begin
    warn_d = warn_i;
    rest_d = warn_q & ~warn_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q <= 1'b0;
      rest_q <= 1'b0;
    end else begin
      warn_q <= warn_d;
      rest_q <= rest_d;
    end
  end

  assign reduce_o  = warn_q;
  assign restore_o = rest_q;
endmodule

// File: rtl/afm_flags.sv
module afm_flags #(
  parameter int unsigned N = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raise_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flg_q, flg_d, clr_eff;
  logic         upd_en;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;
  assign upd_en  = clr_we_i | (|raise_i);

  always_comb begin
    flg_d = (flg_q & ~clr_eff) | raise_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
    end else if (upd_en) begin
      flg_q <= flg_d;
    end
  end

  assign flags_o = flg_q;
endmodule

// File: rtl/amp_fault_mgr.sv
module amp_fault_mgr
  import afm_pkg::*;
#(
  parameter int unsigned RECOVER_CYC = 250
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  therm_warn_i,
  input  logic                  over_temp_i,
  input  logic                  over_curr_i,
  input  logic                  hot_dissip_i,
  input  logic                  vmain_high_i,
  input  logic                  vmain_low_i,
  input  logic                  vaux_low_i,
  input  logic                  win_fault_i,
  input  logic                  pll_unlock_i,
  input  logic                  pll_slow_i,
  input  logic                  clr_we_i,
  input  logic [NUM_FAULTS-1:0] clr_mask_i,
  output logic                  diag_n_o,
  output logic [NUM_FAULTS-1:0] flags_o,
  output logic                  out_float_o,
  output logic                  vol_reduce_o,
  output logic                  vol_restore_o
);
  fault_vec_t                 state;
  logic [NUM_AUTO-1:0]        auto_in, auto_act;
  logic [NUM_RESTART-1:0]     rs_set, rs_good, rs_act;
  logic                       supply_ok, dissip_now;

  assign supply_ok  = ~vmain_high_i & ~vmain_low_i & ~vaux_low_i;
  assign dissip_now = hot_dissip_i & over_curr_i;

  // Auto-recovering class: over-temperature, over-current
  assign auto_in = {over_curr_i, over_temp_i};

  for (genvar a = 0; a < NUM_AUTO; a++) begin : g_auto
    afm_autorec #(.RECOVER_CYC(RECOVER_CYC)) u_rec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fault_i (auto_in[a]),
      .active_o(auto_act[a])
    );
  end

  // Restart class, in order OV, UV, OD, WP, LK, UF
  assign rs_set  = {pll_slow_i, pll_unlock_i, win_fault_i, dissip_now,
                    vmain_low_i | vaux_low_i, vmain_high_i};
  assign rs_good = {~pll_slow_i, ~pll_unlock_i, ~win_fault_i, ~dissip_now,
                    supply_ok, supply_ok};

  for (genvar r = 0; r < NUM_RESTART; r++) begin : g_rst
    afm_restart u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (rs_set[r]),
      .good_i  (rs_good[r]),
      .active_o(rs_act[r])
    );
  end

  afm_thermal u_therm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .warn_i   (therm_warn_i),
    .reduce_o (vol_reduce_o),
    .restore_o(vol_restore_o)
  );

  always_comb begin
    state                 = '0;
    state[IDX_TW]         = vol_reduce_o;
    state[IDX_OT]         = auto_act[0];
    state[IDX_OC]         = auto_act[1];
    state[IDX_UF:IDX_OV]  = rs_act;
  end

  afm_flags #(.N(NUM_FAULTS)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raise_i   (state),
    .clr_we_i  (clr_we_i),
    .clr_mask_i(clr_mask_i),
    .flags_o   (flags_o)
  );

  assign diag_n_o    = ~|(state & DIAG_MASK);
  assign out_float_o =  |(state & FLOAT_MASK);
endmodule

// File: rtl/amp_fault_mgr_chk.sv
module amp_fault_mgr_chk
  import afm_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  over_temp_i,
  input logic                  over_curr_i,
  input logic                  vmain_low_i,
  input logic                  vaux_low_i,
  input logic                  pll_unlock_i,
  input logic                  pll_slow_i,
  input logic                  clr_we_i,
  input logic [NUM_FAULTS-1:0] clr_mask_i,
  input logic                  diag_n_o,
  input logic [NUM_FAULTS-1:0] flags_o,
  input logic                  out_float_o,
  input logic                  vol_reduce_o,
  input logic                  vol_restore_o
);
  logic [1:0] age_q;
  logic       armed1, armed2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  assign armed1 = (age_q >= 2'd2);
  assign armed2 = (age_q == 2'd3);

  // R3
  ot_response_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed1 && $past(over_temp_i)) |-> (!diag_n_o && out_float_o));

  // R5
  uv_diag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed1 && $past(vmain_low_i || vaux_low_i)) |-> (!diag_n_o && out_float_o));

  // R8
  pll_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed1 && $past(pll_unlock_i || pll_slow_i)) |-> out_float_o);

  // R2
  restore_after_fold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed1 && vol_restore_o) |-> (!vol_reduce_o && $past(vol_reduce_o)));

  // R9
  oc_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed2 && $past(over_curr_i, 2)) |-> flags_o[IDX_OC]);

  for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_sticky
    // R10
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed1 && $fell(flags_o[i])) |-> $past(clr_we_i && clr_mask_i[i]));
  end
endmodule

bind amp_fault_mgr amp_fault_mgr_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .over_temp_i  (over_temp_i),
  .over_curr_i  (over_curr_i),
  .vmain_low_i  (vmain_low_i),
  .vaux_low_i   (vaux_low_i),
  .pll_unlock_i (pll_unlock_i),
  .pll_slow_i   (pll_slow_i),
  .clr_we_i     (clr_we_i),
  .clr_mask_i   (clr_mask_i),
  .diag_n_o     (diag_n_o),
  .flags_o      (flags_o),
  .out_float_o  (out_float_o),
  .vol_reduce_o (vol_reduce_o),
  .vol_restore_o(vol_restore_o)
);

// File: tb/amp_fault_mgr_test.sv
`timescale 1ns/1ps
module amp_fault_mgr_test;
  localparam int DLY = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic tw, ot, oc, hot, vhi, vlo, alo, win, unl, slw, cwe;
  logic [8:0] cmask;
  logic diag_n, flt, red, rst_p;
  logic [8:0] flags;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural reference state
  int m_tw, m_rest, m_ot, m_otc, m_oc, m_occ, m_ov, m_uv, m_od, m_wp, m_lk, m_uf;
  logic [8:0] m_flags;

  always #2 clk = ~clk;

  amp_fault_mgr #(.RECOVER_CYC(DLY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .therm_warn_i(tw), .over_temp_i(ot),
    .over_curr_i(oc), .hot_dissip_i(hot), .vmain_high_i(vhi),
    .vmain_low_i(vlo), .vaux_low_i(alo), .win_fault_i(win),
    .pll_unlock_i(unl), .pll_slow_i(slw), .clr_we_i(cwe),
    .clr_mask_i(cmask), .diag_n_o(diag_n), .flags_o(flags),
    .out_float_o(flt), .vol_reduce_o(red), .vol_restore_o(rst_p)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_tw = 0; m_rest = 0; m_ot = 0; m_otc = 0; m_oc = 0; m_occ = 0;
    m_ov = 0; m_uv = 0; m_od = 0; m_wp = 0; m_lk = 0; m_uf = 0;
    m_flags = '0;
  endtask

  task automatic model_step();
    logic [8:0] s;
    int ok;
    s = {m_uf[0], m_lk[0], m_wp[0], m_od[0], m_uv[0], m_ov[0], m_oc[0], m_ot[0], m_tw[0]};
    m_flags = (m_flags & ~(cwe ? cmask : 9'd0)) | s;
    m_rest = (m_tw != 0 && !tw) ? 1 : 0;
    m_tw = tw ? 1 : 0;
    if (ot) begin m_ot = 1; m_otc = 0; end
    else if (m_ot != 0) begin m_otc++; if (m_otc >= DLY) begin m_ot = 0; m_otc = 0; end end
    if (oc) begin m_oc = 1; m_occ = 0; end
    else if (m_oc != 0) begin m_occ++; if (m_occ >= DLY) begin m_oc = 0; m_occ = 0; end end
    ok = (!vhi && !vlo && !alo) ? 1 : 0;
    if (vhi) m_ov = 1; else if (ok != 0) m_ov = 0;
    if (vlo || alo) m_uv = 1; else if (ok != 0) m_uv = 0;
    m_od = (hot && oc) ? 1 : 0;
    m_wp = win ? 1 : 0;
    m_lk = unl ? 1 : 0;
    m_uf = slw ? 1 : 0;
  endtask

  task automatic compare();
    int ed, ef;
    ed = (m_ot | m_oc | m_ov | m_uv | m_od | m_wp) != 0 ? 0 : 1;
    ef = (m_ot | m_oc | m_ov | m_uv | m_od | m_wp | m_lk | m_uf) != 0 ? 1 : 0;
    check("R11 diag model", diag_n, ed);
    check("R11 float model", flt, ef);
    check("R2 reduce model", red, m_tw);
    check("R2 restore model", rst_p, m_rest);
    check("R9 flags model", flags, m_flags);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (!rst_n) model_clear(); else model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tw = 0; ot = 0; oc = 0; hot = 0; vhi = 0; vlo = 0; alo = 0;
    win = 0; unl = 0; slw = 0; cwe = 0; cmask = '0;
    model_clear();
    ticks(3);
    rst_n = 1;
    ticks(2);
    // R1 reset state
    check("R1 diag", diag_n, 1);
    check("R1 float", flt, 0);
    check("R1 flags", flags, 0);
    check("R1 reduce", red, 0);
    check("R1 restore", rst_p, 0);

    // R2 thermal foldback
    tw = 1; tick();
    check("R2 reduce on", red, 1);
    check("R2 no diag", diag_n, 1);
    check("R2 no float", flt, 0);
    ticks(4);
    tw = 0; tick();
    check("R2 reduce off", red, 0);
    check("R2 restore pulse", rst_p, 1);
    tick();
    check("R2 restore single", rst_p, 0);
    check("R9 tw flag sticky", flags[0], 1);
    cwe = 1; cmask = 9'h1FF; tick(); cwe = 0; cmask = '0; tick();

    // R3 over-temperature auto recovery
    ot = 1; ticks(3);
    check("R3 ot diag", diag_n, 0);
    check("R3 ot float", flt, 1);
    ot = 0; ticks(DLY - 1);
    check("R3 still held", flt, 1);
    tick();
    check("R3 released float", flt, 0);
    check("R3 released diag", diag_n, 1);
    check("R9 ot flag", flags[1], 1);

    // R4 reassertion restarts wait (over-current)
    oc = 1; tick(); oc = 0; ticks(5);
    oc = 1; tick(); oc = 0; ticks(DLY - 1);
    check("R4 restart held", diag_n, 0);
    tick();
    check("R4 released", diag_n, 1);
    check("R9 oc flag", flags[2], 1);

    // R5 supply faults
    vlo = 1; tick();
    check("R5 uv diag", diag_n, 0);
    vlo = 0; alo = 1; ticks(2);
    check("R5 aux low holds", flt, 1);
    alo = 0; vhi = 1; ticks(2);
    check("R5 ov holds", diag_n, 0);
    check("R9 uv flag", flags[4], 1);
    vhi = 0; tick();
    check("R5 released", flt, 0);
    check("R9 ov flag", flags[3], 1);
    cwe = 1; cmask = 9'h1FF; tick(); cwe = 0; cmask = '0; tick();

    // R6 over-dissipation
    hot = 1; ticks(3);
    check("R6 hot alone", flags[5], 0);
    check("R6 hot alone float", flt, 0);
    oc = 1; ticks(2);
    check("R6 od flag", flags[5], 1);
    hot = 0; ticks(2);
    oc = 0; ticks(DLY + 2);
    check("R6 all clear", flt, 0);

    // R7 window fault
    win = 1; tick();
    check("R7 win diag", diag_n, 0);
    check("R7 win float", flt, 1);
    win = 0; tick();
    check("R7 win release", flt, 0);
    check("R9 win flag", flags[6], 1);
    cwe = 1; cmask = 9'h1FF; tick(); cwe = 0; cmask = '0; tick();

    // R8 PLL faults
    unl = 1; ticks(2);
    check("R8 unlock float", flt, 1);
    check("R8 unlock no diag", diag_n, 1);
    slw = 1; ticks(2);
    check("R8 slow no diag", diag_n, 1);
    check("R9 lk uf flags", flags[8:7], 3);

    // R10 W1C: active fault re-sets, mask-zero bits untouched
    cwe = 1; cmask = 9'h080; tick(); cwe = 0; cmask = '0;
    check("R10 active keeps lk", flags[7], 1);
    check("R10 unmasked uf kept", flags[8], 1);
    unl = 0; slw = 0; ticks(2);
    cwe = 1; cmask = 9'h100; tick(); cwe = 0; cmask = '0;
    check("R10 uf cleared", flags[8], 0);
    check("R10 lk untouched", flags[7], 1);
    cmask = 9'h1FF; tick(); cmask = '0;
    check("R10 mask without strobe", flags[7], 1);
    cwe = 1; cmask = 9'h1FF; tick(); cwe = 0; cmask = '0;
    check("R10 all cleared", flags, 0);
    ticks(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule